// File: doc/BRIEF.md
# Indirect Extended-Register Access Bridge

This block sits behind a 32-entry management register interface and opens a window into a larger 16-bit-addressed extended register space through two registers, a control register and a data register. The control register holds a two-bit function code and a five-bit device address. The data register either loads a stored 16-bit pointer or reads and writes the extended location that the pointer names. The data-access functions can advance the pointer automatically after each access.

Behind the pair sits a small register file for one device address. It holds ten 8-bit LED configuration cells at extended locations 0x01E0 to 0x01E9. Software reaches a cell in four steps: it selects the address function, writes the location number, selects a data function, and then writes or reads the data register.

Top module: `xreg_bridge`

## Requirements
- R1: After reset the control register reads 0x0000, the pointer is 0x0000 and mgmt_rdata is 0x0000. Cells 0x01E0..0x01E9 hold, in ascending order, 0xC5, 0x67, 0x70, 0x03, 0x20, 0x00, 0x40, 0x00, 0x40, 0x20.
- R2: A write to management address 0x0D stores bits 15:14 as the function code and bits 4:0 as the device address. Reading 0x0D returns those fields in the same positions and zero in bits 13:5.
- R3: When the function code is 00 (address), a write to management address 0x0E loads the pointer and a read of 0x0E returns the pointer. Read data appears on mgmt_rdata in the cycle after the read strobe and holds until the next accepted read.
- R4: When the function code is 01 and the device address is 0x1F, a read or write of 0x0E accesses the cell named by the pointer, and the pointer does not change.
- R5: When the function code is 10 and the device address is 0x1F, the pointer increments by one after every data read and every data write. It wraps from 0xFFFF to 0x0000.
- R6: When the function code is 11 and the device address is 0x1F, the pointer increments after data writes only. Data reads leave the pointer unchanged.
- R7: In a data function with a device address other than 0x1F, a data read returns 0x0000, a data write changes no cell, and the pointer does not move.
- R8: Extended locations outside 0x01E0..0x01E9 read as 0x0000, and writes to them are discarded. Bits 15:8 of every cell read as zero.
- R9: Management addresses other than 0x0D and 0x0E read as 0x0000, and writes to them change nothing.
- R10: A read strobe that arrives in the same cycle as a write strobe is ignored: mgmt_rdata keeps its value and the pointer does not move for that read. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_addr | input | 5 | Management register address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_wr | input | 1 | Write strobe, one cycle per access |
| mgmt_rd | input | 1 | Read strobe, one cycle per access |
| mgmt_rdata | output | 16 | Registered read data |

## Verification
The main function is exercised through each of the four function codes.

Repeated reads in plain data mode are contrasted with reads in both increment modes. This separates "never advance" from "advance on any access" and from "advance on writes only". Each increment case is confirmed by switching back to the address function and reading the pointer directly.

A mismatched device address is paired with both plain and incrementing functions. This shows that such accesses leave both the cells and the pointer untouched. Locations just past the implemented range, a far-away location and the 0xFFFF wrap separate the implemented window from the rest of the space.

// File: rtl/xreg_pkg.sv
package xreg_pkg;

   typedef enum logic [1:0] {
      FN_ADDR   = 2'b00,
      FN_DATA   = 2'b01,
      FN_INC_RW = 2'b10,
      FN_INC_WR = 2'b11
   } xfn_e;

   // Power-up contents of the LED configuration cells, by index from the base.
   function automatic logic [7:0] cell_reset(input int idx);
      case (idx)
         0:       return 8'hC5;
         1:       return 8'h67;
         2:       return 8'h70;
         3:       return 8'h03;
         4:       return 8'h20;
         5:       return 8'h00;
         6:       return 8'h40;
         7:       return 8'h00;
         8:       return 8'h40;
         9:       return 8'h20;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/xreg_ctrl.sv
module xreg_ctrl
   import xreg_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DW-1:0]    wdata,
   output xfn_e             fn,
   output logic [DEV_W-1:0] devad,
   output logic [DW-1:0]    ctrl_value
);
   localparam int FN_LSB = DW - 2;

   if (DEV_W > FN_LSB) begin : g_bad_devw
      $error("xreg_ctrl: DEV_W overlaps the function field");
   end

   xfn_e             fn_q;
   logic [DEV_W-1:0] dev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fn_q  <= FN_ADDR;
         dev_q <= '0;
      end else if (wr_en) begin
         fn_q  <= xfn_e'(wdata[DW-1:FN_LSB]);
         dev_q <= wdata[DEV_W-1:0];
      end
   end

   always_comb begin
      ctrl_value                 = '0;
      ctrl_value[DW-1:FN_LSB]    = fn_q;
      ctrl_value[DEV_W-1:0]      = dev_q;
   end

   assign fn    = fn_q;
   assign devad = dev_q;

   // R2
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctrl_value));

endmodule

// File: rtl/xreg_ptr.sv
module xreg_ptr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] ptr
);
   if (AW < 1) begin : g_bad_aw
      $error("xreg_ptr: AW must be positive");
   end

   logic [AW-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    ptr_q <= '0;
      else if (load) ptr_q <= load_val;
      else if (step) ptr_q <= ptr_q + AW'(1);
   end

   assign ptr = ptr_q;

   // R5
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> ptr == $past(ptr) + AW'(1));

   // R4
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(ptr));

endmodule

// File: rtl/xreg_file.sv
module xreg_file
   import xreg_pkg::*;
#(
   parameter int          AW     = 16,
   parameter int          DW     = 16,
   parameter int          CELL_W = 8,
   parameter logic [15:0] BASE   = 16'h01E0,
   parameter int          COUNT  = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   if (CELL_W > DW) begin : g_bad_cw
      $error("xreg_file: CELL_W exceeds DW");
   end
   if (COUNT < 1 || COUNT > 256) begin : g_bad_cnt
      $error("xreg_file: COUNT out of range");
   end

   logic [CELL_W-1:0] cell_q [COUNT];
   logic [COUNT-1:0]  sel;

   for (genvar i = 0; i < COUNT; i++) begin : g_cell
      localparam logic [AW-1:0] CELL_ADDR = AW'(BASE) + AW'(i);
      assign sel[i] = (addr == CELL_ADDR);

      always_ff @(posedge clk) begin
         if (!rst_n)               cell_q[i] <= cell_reset(i);
         else if (wr_en && sel[i]) cell_q[i] <= wdata[CELL_W-1:0];
      end

      // R8
      cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && sel[i]) |=> $stable(cell_q[i]));
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < COUNT; i++) begin
         if (sel[i]) rdata[CELL_W-1:0] = rdata[CELL_W-1:0] | cell_q[i];
      end
   end

   // R8
   sel_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

endmodule

// File: rtl/xreg_bridge.sv
module xreg_bridge
   import xreg_pkg::*;
#(
   parameter int          MGMT_AW    = 5,
   parameter int          DW         = 16,
   parameter int          DEV_W      = 5,
   parameter logic [4:0]  DEVAD      = 5'h1F,
   parameter logic [4:0]  CTRL_ADDR  = 5'h0D,
   parameter logic [4:0]  DATA_ADDR  = 5'h0E,
   parameter logic [15:0] FILE_BASE  = 16'h01E0,
   parameter int          FILE_COUNT = 10,
   parameter int          CELL_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [MGMT_AW-1:0] mgmt_addr,
   input  logic [DW-1:0]      mgmt_wdata,
   input  logic               mgmt_wr,
   input  logic               mgmt_rd,
   output logic [DW-1:0]      mgmt_rdata
);
   localparam int PTR_W = DW;

   if (MGMT_AW < 4 || MGMT_AW > 5) begin : g_bad_maw
      $error("xreg_bridge: MGMT_AW must be 4 or 5");
   end
   if (CTRL_ADDR == DATA_ADDR) begin : g_bad_pair
      $error("xreg_bridge: control and data addresses collide");
   end

   xfn_e             fn;
   logic [DEV_W-1:0] devad;
   logic [DW-1:0]    ctrl_value;
   logic [PTR_W-1:0] ptr;
   logic [DW-1:0]    file_rdata;
   logic [DW-1:0]    rd_next;
   logic [DW-1:0]    rdata_q;

   logic ctl_sel, dat_sel, rd_eff, wr_ctl, wr_dat, rd_dat;
   logic dev_ok, ptr_load, ptr_step, file_we;

   assign ctl_sel  = (mgmt_addr == CTRL_ADDR[MGMT_AW-1:0]);
   assign dat_sel  = (mgmt_addr == DATA_ADDR[MGMT_AW-1:0]);
   assign rd_eff   = mgmt_rd && !mgmt_wr;
   assign wr_ctl   = mgmt_wr && ctl_sel;
   assign wr_dat   = mgmt_wr && dat_sel;
   assign rd_dat   = rd_eff && dat_sel;
   assign dev_ok   = (devad == DEVAD[DEV_W-1:0]);
   assign ptr_load = wr_dat && (fn == FN_ADDR);
   assign file_we  = wr_dat && (fn != FN_ADDR) && dev_ok;
   assign ptr_step = dev_ok &&
                     ((wr_dat && (fn == FN_INC_RW || fn == FN_INC_WR)) ||
                      (rd_dat && fn == FN_INC_RW));

   xreg_ctrl #(.DW(DW), .DEV_W(DEV_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_ctl),
      .wdata      (mgmt_wdata),
      .fn         (fn),
      .devad      (devad),
      .ctrl_value (ctrl_value)
   );

   xreg_ptr #(.AW(PTR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (mgmt_wdata),
      .step     (ptr_step),
      .ptr      (ptr)
   );

   xreg_file #(
      .AW     (PTR_W),
      .DW     (DW),
      .CELL_W (CELL_W),
      .BASE   (FILE_BASE),
      .COUNT  (FILE_COUNT)
   ) u_file (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (ptr),
      .wr_en (file_we),
      .wdata (mgmt_wdata),
      .rdata (file_rdata)
   );

   always_comb begin
      rd_next = '0;
      if (ctl_sel) begin
         rd_next = ctrl_value;
      end else if (dat_sel) begin
         if (fn == FN_ADDR) rd_next = ptr;
         else if (dev_ok)   rd_next = file_rdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_eff) rdata_q <= rd_next;
   end

   assign mgmt_rdata = rdata_q;

   // R3
   addr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dat && fn == FN_ADDR) |=> mgmt_rdata == $past(ptr));

   // R7
   foreign_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dat && fn != FN_ADDR && !dev_ok) |=> mgmt_rdata == '0);

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_eff |=> $stable(mgmt_rdata));

   // R6
   no_rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dat && fn == FN_INC_WR) |-> !ptr_step);

endmodule

// File: tb/xreg_bridge_tb.sv
`timescale 1ns/1ps
module xreg_bridge_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  mgmt_addr = '0;
   logic [15:0] mgmt_wdata = '0;
   logic        mgmt_wr = 1'b0;
   logic        mgmt_rd = 1'b0;
   logic [15:0] mgmt_rdata;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   xreg_bridge u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .mgmt_addr  (mgmt_addr),
      .mgmt_wdata (mgmt_wdata),
      .mgmt_wr    (mgmt_wr),
      .mgmt_rd    (mgmt_rd),
      .mgmt_rdata (mgmt_rdata)
   );

   // Vector: {is_read, mgmt address, write value or expected read, requirement}
   localparam logic       W  = 1'b0;
   localparam logic       RD = 1'b1;
   localparam logic [4:0] C  = 5'h0D;
   localparam logic [4:0] D  = 5'h0E;
   localparam int NV = 66;
   localparam logic [25:0] VEC [NV] = '{
      {W,C,16'h001F,4'd0}, {RD,C,16'h001F,4'd2},            // R2 fields
      {W,C,16'hFFFF,4'd0}, {RD,C,16'hC01F,4'd2},            // R2 reserved zero
      {W,C,16'h001F,4'd0}, {W,D,16'h01E0,4'd0},
      {RD,D,16'h01E0,4'd3},                                  // R3 pointer read
      {W,C,16'h401F,4'd0}, {RD,D,16'h00C5,4'd1},            // R1 reset value
      {RD,D,16'h00C5,4'd4},                                  // R4 no advance
      {W,D,16'h12AB,4'd0}, {RD,D,16'h00AB,4'd8},            // R8 upper bits zero
      {W,C,16'h001F,4'd0}, {W,D,16'h01E8,4'd0},
      {W,C,16'h401F,4'd0}, {RD,D,16'h0040,4'd1},            // R1
      {W,C,16'h001F,4'd0}, {W,D,16'h01E1,4'd0},
      {W,C,16'h801F,4'd0}, {RD,D,16'h0067,4'd5},            // R5 read advance
      {RD,D,16'h0070,4'd5}, {RD,D,16'h0003,4'd5},
      {W,C,16'h001F,4'd0}, {RD,D,16'h01E4,4'd5},
      {W,C,16'hC01F,4'd0}, {RD,D,16'h0020,4'd6},            // R6 reads hold
      {RD,D,16'h0020,4'd6},
      {W,D,16'h0055,4'd0}, {W,D,16'h0066,4'd0},
      {W,C,16'h001F,4'd0}, {RD,D,16'h01E6,4'd6},            // R6 writes advance
      {W,D,16'h01E4,4'd0}, {W,C,16'h401F,4'd0}, {RD,D,16'h0055,4'd6},
      {W,C,16'h001F,4'd0}, {W,D,16'h01E5,4'd0},
      {W,C,16'h401F,4'd0}, {RD,D,16'h0066,4'd6},
      {W,C,16'h4005,4'd0}, {RD,D,16'h0000,4'd7},            // R7 foreign device
      {W,D,16'h00FF,4'd0}, {W,C,16'h401F,4'd0},
      {RD,D,16'h0066,4'd7},
      {W,C,16'h8005,4'd0}, {RD,D,16'h0000,4'd7},
      {W,C,16'h001F,4'd0}, {RD,D,16'h01E5,4'd7},
      {W,D,16'h0100,4'd0}, {W,C,16'h401F,4'd0},
      {RD,D,16'h0000,4'd8},                                  // R8 far location
      {W,D,16'hBEEF,4'd0}, {RD,D,16'h0000,4'd8},
      {W,C,16'h001F,4'd0}, {W,D,16'h01EA,4'd0},
      {W,C,16'h401F,4'd0}, {RD,D,16'h0000,4'd8},            // R8 past the top
      {W,5'h00,16'h1234,4'd0}, {RD,5'h00,16'h0000,4'd9},    // R9
      {RD,C,16'h401F,4'd9}, {RD,5'h1F,16'h0000,4'd9},
      {W,C,16'h001F,4'd0}, {W,D,16'hFFFF,4'd0},
      {W,C,16'h801F,4'd0}, {W,D,16'h0000,4'd0},
      {W,C,16'h001F,4'd0}, {RD,D,16'h0000,4'd5}             // R5 wrap
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [4:0] a, input logic [15:0] v);
      @(negedge clk);
      mgmt_addr = a; mgmt_wdata = v; mgmt_wr = 1'b1;
      @(negedge clk);
      mgmt_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      mgmt_addr = a; mgmt_rd = 1'b1;
      @(negedge clk);
      mgmt_rd = 1'b0;
      check(tag, mgmt_rdata, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 rdata after reset", mgmt_rdata, 16'h0000);
      do_rd(C, 16'h0000, "R1 control after reset");

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][25]) do_rd(VEC[i][24:20], VEC[i][19:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
         else            do_wr(VEC[i][24:20], VEC[i][19:4]);
      end

      // R10 read together with write is dropped
      do_rd(C, 16'h001F, "R10 baseline");
      @(negedge clk);
      mgmt_addr = C; mgmt_wdata = 16'h401F; mgmt_wr = 1'b1; mgmt_rd = 1'b1;
      @(negedge clk);
      mgmt_wr = 1'b0; mgmt_rd = 1'b0;
      check("R10 rdata held", mgmt_rdata, 16'h001F);
      do_rd(C, 16'h401F, "R10 write applied");

      // R1 reset mid-run restores control and cells
      do_wr(C, 16'h001F); do_wr(D, 16'h01E0); do_wr(C, 16'h401F); do_wr(D, 16'h0011);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      check("R1 rdata after second reset", mgmt_rdata, 16'h0000);
      do_rd(C, 16'h0000, "R1 control after second reset");
      do_rd(D, 16'h0000, "R1 pointer after second reset");
      do_wr(C, 16'h401F); do_wr(C, 16'h001F); do_wr(D, 16'h01E0); do_wr(C, 16'h401F);
      do_rd(D, 16'h00C5, "R1 cell restored");
      do_wr(C, 16'h001F); do_wr(D, 16'h01E9); do_wr(C, 16'h401F);
      do_rd(D, 16'h0020, "R1 last cell");

      finish_run();
   end

   initial begin
      for (int n = 0; n < 20000; n++) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

endmodule